// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, write-back). Each cycle it looks at the register numbers read by the instruction in decode and by the instruction in execute. It also looks at the destination number, the write-enable and the load marker held in the later pipeline registers. From these it picks where each ALU operand comes from, and it decides whether the front of the pipe must wait or drop an instruction.

Operands normally come from the register file. An ALU result still in flight is bypassed from the memory-stage or write-back-stage pipeline register. The nearer producer wins. The register file writes in the first half of a cycle and reads in the second, so the decode stage never needs a bypass. A value being loaded cannot reach an instruction directly behind the load in time. The block then holds the PC and the fetch/decode register for one cycle and sends a no-op into execute. Branches are assumed not taken and are resolved in decode. When one turns out taken, the block kills the single instruction fetched behind it.

The block is purely combinational. The clock and the synchronous active-low reset serve only its embedded properties.

Top module: `hazard_unit`

## Requirements
- R1: Operand select is 2'b10 (memory-stage bypass) when the memory stage writes a register, is not a load, its destination is nonzero and it equals that operand's source number.
- R2: Operand select is 2'b01 (write-back bypass) when R1 does not apply and the write-back stage writes a nonzero destination equal to that operand's source number.
- R3: When both the memory and write-back stages match an operand, the memory-stage bypass (2'b10) is chosen.
- R4: Register 0 is never bypassed (select 2'b00) and never causes a stall.
- R5: A stage whose write-enable is clear never causes a bypass or a stall; with no match the select is 2'b00 (register file).
- R6: When execute holds a load that writes a nonzero register equal to either decode source, stall and bubble are both 1 in that cycle.
- R7: A non-load instruction in execute never causes a stall. A producer followed by four readers of its result runs with no stall: the first reader gets 2'b10, the second 2'b01 and the third 2'b00.
- R8: Squash equals branch-taken while no stall is raised, and is 0 during a stall. A taken branch costs exactly one killed instruction.
- R9: A load followed directly by a user of its result costs exactly one stall cycle, after which the user reads the loaded value through the write-back bypass (2'b01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded properties |
| rst_n | input | 1 | Synchronous active-low reset, disables the properties |
| id_rs1_i | input | 5 | First source register of the decode instruction |
| id_rs2_i | input | 5 | Second source register of the decode instruction |
| ex_rs1_i | input | 5 | First source register of the execute instruction |
| ex_rs2_i | input | 5 | Second source register of the execute instruction |
| ex_rd_i | input | 5 | Destination of the execute instruction |
| ex_wr_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | 5 | Destination held in the memory stage |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | 5 | Destination held in the write-back stage |
| wb_wr_i | input | 1 | Write-back instruction writes a register |
| br_taken_i | input | 1 | Branch in decode resolved taken |
| fwd_a_o | output | 2 | Source select for ALU operand A (00 file, 01 write-back, 10 memory) |
| fwd_b_o | output | 2 | Source select for ALU operand B |
| stall_o | output | 1 | Hold PC and the fetch/decode register |
| bubble_o | output | 1 | Insert a no-op into execute |
| squash_o | output | 1 | Kill the instruction just fetched |

## Verification
The bench targets the case where both later stages write the operand's register. A design with the priority reversed would feed a stale value from write-back. Register 0 is used as a destination with write-enable set; a design that forgets the zero check would bypass or stall on it. A taken branch is raised while a load-use stall is pending; a design that kills the fetch anyway would lose the held instruction. Short programs run through a bench-side pipeline to count stalls and kills for the back-to-back reader, load-use and taken-branch sequences. A wrong count or the wrong bypass for the instruction after the stall is reported.

// File: rtl/hzd_pkg.sv
// Package: shared encodings for the hazard controller.
// Assumes a register index width fixed per build by the top parameter.
package hzd_pkg;

    // ALU operand source; encoding is decoded by the datapath muxes.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } opnd_src_e;

endpackage

// File: rtl/hzd_fwd_select.sv
// Module: picks the source of one ALU operand in execute.
// Assumes: a load in the memory stage never matches here, because the
// load-use interlock kept its consumer out of execute for a cycle.
// Register 0 is a constant and is never bypassed.
module hzd_fwd_select
    import hzd_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] src_idx,
    input  logic             mem_wr,
    input  logic             mem_ld,
    input  logic [IDX_W-1:0] mem_rd,
    input  logic             wb_wr,
    input  logic [IDX_W-1:0] wb_rd,
    output opnd_src_e        sel
);

    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic src_live;
    logic hit_mem;
    logic hit_wb;

    // Qualify each producer stage against this operand.
    always_comb begin
        src_live = (src_idx != ZERO_IDX);
        hit_mem  = src_live && mem_wr && !mem_ld && (mem_rd == src_idx);
        hit_wb   = src_live && wb_wr && (wb_rd == src_idx);
    end

    // Nearest producer wins; fall back to the register file.
    always_comb begin
        if (hit_mem)     sel = SRC_MEM;
        else if (hit_wb) sel = SRC_WB;
        else             sel = SRC_REGFILE;
    end

    // R4: register 0 always reads the file.
    assert_zero_not_bypassed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_idx == ZERO_IDX) |-> (sel == SRC_REGFILE));

    // R5: without any enabled producer the file is used.
    assert_no_enable_no_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr && !wb_wr) |-> (sel == SRC_REGFILE));

    // R1: a load in the memory stage is never a bypass source.
    assert_load_not_mem_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ld |-> (sel != SRC_MEM));

endmodule

// File: rtl/hzd_load_interlock.sv
// Module: detects a decode instruction reading the destination of a load
// now in execute. Assumes the loaded value is first available at the end
// of the memory stage, so one cycle of hold is always enough.
module hzd_load_interlock #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned N_SRC = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ex_wr,
    input  logic                        ex_ld,
    input  logic [IDX_W-1:0]            ex_rd,
    input  logic [N_SRC-1:0][IDX_W-1:0] id_src,
    output logic                        hold
);

    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic             ld_pending;
    logic [N_SRC-1:0] src_hit;

    // A load with a real destination is sitting in execute.
    always_comb ld_pending = ex_wr && ex_ld && (ex_rd != ZERO_IDX);

    // Compare every decode source with the pending load destination.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        always_comb src_hit[g] = ld_pending && (id_src[g] == ex_rd);
    end

    // Any matching source holds the front of the pipe.
    always_comb hold = |src_hit;

    // R7: non-load producers never hold the pipe.
    assert_alu_no_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_ld |-> !hold);

    // R5: a disabled write never holds the pipe.
    assert_nowrite_no_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_wr |-> !hold);

endmodule

// File: rtl/hzd_branch_squash.sv
// Module: kills the wrong-path fetch after a taken branch in decode.
// Assumes a held decode stage has no final branch outcome yet, so no kill
// is issued while the pipe is held.
module hzd_branch_squash (
    input  logic clk,
    input  logic rst_n,
    input  logic br_taken,
    input  logic hold,
    output logic squash
);

    // Kill only when the branch actually leaves decode this cycle.
    always_comb squash = br_taken && !hold;

    // R8: never kill while the front is held.
    assert_no_kill_on_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !squash);

endmodule

// File: rtl/hazard_unit.sv
// Module: top of the hazard controller for a five-stage in-order pipe.
// Produces operand bypass selects for execute, a one-cycle load-use hold
// with a bubble into execute, and a kill of the fetch after a taken branch.
// Assumes a split-cycle register file (write before read), so decode
// needs no bypass. Purely combinational; clk/rst_n feed the properties.
module hazard_unit
    import hzd_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] id_rs1_i,
    input  logic [IDX_W-1:0] id_rs2_i,
    input  logic [IDX_W-1:0] ex_rs1_i,
    input  logic [IDX_W-1:0] ex_rs2_i,
    input  logic [IDX_W-1:0] ex_rd_i,
    input  logic             ex_wr_i,
    input  logic             ex_load_i,
    input  logic [IDX_W-1:0] mem_rd_i,
    input  logic             mem_wr_i,
    input  logic             mem_load_i,
    input  logic [IDX_W-1:0] wb_rd_i,
    input  logic             wb_wr_i,
    input  logic             br_taken_i,
    output logic [1:0]       fwd_a_o,
    output logic [1:0]       fwd_b_o,
    output logic             stall_o,
    output logic             bubble_o,
    output logic             squash_o
);

    localparam int unsigned N_OPND = 2;

    logic [N_OPND-1:0][IDX_W-1:0] ex_src;
    logic [N_OPND-1:0][IDX_W-1:0] id_src;
    opnd_src_e                    sel [N_OPND];
    logic                         hold;

    // Gather operand numbers into indexed vectors.
    always_comb begin
        ex_src[0] = ex_rs1_i;
        ex_src[1] = ex_rs2_i;
        id_src[0] = id_rs1_i;
        id_src[1] = id_rs2_i;
    end

    // One bypass selector per ALU operand.
    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        hzd_fwd_select #(.IDX_W(IDX_W)) i_sel (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_idx (ex_src[g]),
            .mem_wr  (mem_wr_i),
            .mem_ld  (mem_load_i),
            .mem_rd  (mem_rd_i),
            .wb_wr   (wb_wr_i),
            .wb_rd   (wb_rd_i),
            .sel     (sel[g])
        );
    end

    hzd_load_interlock #(.IDX_W(IDX_W), .N_SRC(N_OPND)) i_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .ex_wr  (ex_wr_i),
        .ex_ld  (ex_load_i),
        .ex_rd  (ex_rd_i),
        .id_src (id_src),
        .hold   (hold)
    );

    hzd_branch_squash i_kill (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_taken (br_taken_i),
        .hold     (hold),
        .squash   (squash_o)
    );

    // Drive the outward control signals.
    always_comb begin
        fwd_a_o  = sel[0];
        fwd_b_o  = sel[1];
        stall_o  = hold;
        bubble_o = hold;
    end

    // R3: the memory stage wins over write-back for operand A.
    assert_mem_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_i && !mem_load_i && wb_wr_i && (mem_rd_i == ex_rs1_i)
         && (wb_rd_i == ex_rs1_i) && (ex_rs1_i != '0)) |-> (fwd_a_o == 2'b10));

    // R6: a load feeding decode holds the front and bubbles execute.
    assert_load_use_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_wr_i && ex_load_i && (ex_rd_i != '0) && (ex_rd_i == id_rs2_i))
        |-> (stall_o && bubble_o));

    // R4: destination 0 in execute never holds the pipe.
    assert_zero_no_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd_i == '0) |-> !stall_o);

endmodule

// File: tb/test_hazard_unit.sv
// Bench: behavioural reference compared every clock, plus short programs
// run through a bench-side pipeline model.
module test_hazard_unit;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic ex_wr, ex_ld, mem_wr, mem_ld, wb_wr, br;
    logic [1:0] fwd_a, fwd_b;
    logic stall, bubble, squash;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    hazard_unit i_hazard_unit (
        .clk(clk), .rst_n(rst_n),
        .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
        .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
        .ex_wr_i(ex_wr), .ex_load_i(ex_ld),
        .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .mem_load_i(mem_ld),
        .wb_rd_i(wb_rd), .wb_wr_i(wb_wr), .br_taken_i(br),
        .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
        .stall_o(stall), .bubble_o(bubble), .squash_o(squash)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected operand source per the requirement text (R1, R2, R3, R4, R5).
    function automatic int exp_src(input logic [4:0] s);
        if (s == 0) return 0;
        if (mem_wr && !mem_ld && mem_rd == s) return 2;
        if (wb_wr && wb_rd == s) return 1;
        return 0;
    endfunction

    function automatic int exp_hold();
        if (!(ex_wr && ex_ld) || ex_rd == 0) return 0;
        return (ex_rd == id_rs1 || ex_rd == id_rs2) ? 1 : 0;
    endfunction

    // Compare every output with the reference in the current cycle.
    task automatic cmp_all(input string tag);
        int h;
        h = exp_hold();
        chk({tag, " fwd_a R1/R2/R3"}, fwd_a, exp_src(ex_rs1));
        chk({tag, " fwd_b R1/R2/R3"}, fwd_b, exp_src(ex_rs2));
        chk({tag, " stall R6"}, stall, h);
        chk({tag, " bubble R6"}, bubble, h);
        chk({tag, " squash R8"}, squash, (br && h == 0) ? 1 : 0);
    endtask

    task automatic clear_in();
        {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
        {ex_wr, ex_ld, mem_wr, mem_ld, wb_wr, br} = '0;
    endtask

    task automatic step(input string tag);
        #4;
        cmp_all(tag);
        @(negedge clk);
    endtask

    // Bench-side pipeline program runner.
    typedef struct packed {
        logic       v;
        logic [3:0] tag;
        logic [4:0] rd, rs1, rs2;
        logic       wr, ld, br;
    } ins_t;

    ins_t prog [8];
    int   plen;
    int   n_stall, n_kill;
    int   fwd_seen [16];

    task automatic run_prog(input string name);
        ins_t id_s, ex_s, mem_s, wb_s, nop;
        int pc;
        nop = '0;
        id_s = nop; ex_s = nop; mem_s = nop; wb_s = nop;
        pc = 0; n_stall = 0; n_kill = 0;
        for (int k = 0; k < 16; k++) fwd_seen[k] = -1;
        for (int cyc = 0; cyc < 14; cyc++) begin
            // advance happens after the compare of the previous cycle
            id_rs1 = id_s.v ? id_s.rs1 : 5'd0;
            id_rs2 = id_s.v ? id_s.rs2 : 5'd0;
            br     = id_s.v && id_s.br;
            ex_rs1 = ex_s.rs1; ex_rs2 = ex_s.rs2; ex_rd = ex_s.rd;
            ex_wr  = ex_s.v && ex_s.wr; ex_ld = ex_s.v && ex_s.ld;
            mem_rd = mem_s.rd; mem_wr = mem_s.v && mem_s.wr; mem_ld = mem_s.v && mem_s.ld;
            wb_rd  = wb_s.rd; wb_wr = wb_s.v && wb_s.wr;
            #4;
            cmp_all(name);
            if (ex_s.v) fwd_seen[ex_s.tag] = fwd_a;
            wb_s = mem_s; mem_s = ex_s;
            if (stall) begin
                n_stall++;
                ex_s = nop;
            end else begin
                ex_s = id_s;
                if (squash) begin
                    n_kill++;
                    pc++;
                    id_s = nop;
                end else begin
                    id_s = (pc < plen) ? prog[pc] : nop;
                    pc++;
                end
            end
            @(negedge clk);
        end
    endtask

    function automatic ins_t mk(input int t, input int rd, input int rs1, input int rs2,
                                input bit wr, input bit ld, input bit b);
        ins_t x;
        x.v = 1'b1; x.tag = 4'(t); x.rd = 5'(rd); x.rs1 = 5'(rs1); x.rs2 = 5'(rs2);
        x.wr = wr; x.ld = ld; x.br = b;
        return x;
    endfunction

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clear_in();
        @(negedge clk); @(negedge clk);
        #2;
        chk("reset stall R6", stall, 0);
        chk("reset squash R8", squash, 0);
        chk("reset fwd_a R5", fwd_a, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: both stages hold r5; memory stage must win.
        clear_in(); ex_rs1 = 5; ex_rs2 = 5; mem_rd = 5; mem_wr = 1; wb_rd = 5; wb_wr = 1;
        step("R3 priority");
        // R4: register 0 written in both stages.
        clear_in(); mem_wr = 1; wb_wr = 1; ex_wr = 1; ex_ld = 1;
        br = 1;
        step("R4 zero");
        chk("R4 fwd_a zero", fwd_a, 0);
        // R5: matching numbers but writes disabled.
        clear_in(); ex_rs1 = 7; mem_rd = 7; wb_rd = 7; ex_rd = 9; ex_ld = 1; id_rs1 = 9;
        step("R5 disabled");
        // R1: load in memory stage falls back to write-back.
        clear_in(); ex_rs2 = 3; mem_rd = 3; mem_wr = 1; mem_ld = 1; wb_rd = 3; wb_wr = 1;
        step("R1 load mem");
        chk("R1 load in mem gives wb", fwd_b, 1);
        // R8 with R6: taken branch during a load-use hold.
        clear_in(); ex_rd = 4; ex_wr = 1; ex_ld = 1; id_rs2 = 4; br = 1;
        step("R8 hold");
        // R7: ALU producer in execute with matching decode source.
        clear_in(); ex_rd = 4; ex_wr = 1; id_rs1 = 4;
        step("R7 alu");

        // R7: producer then four readers of r1.
        plen = 5;
        prog[0] = mk(0, 1, 2, 3, 1, 0, 0);
        prog[1] = mk(1, 4, 1, 3, 1, 0, 0);
        prog[2] = mk(2, 6, 1, 7, 1, 0, 0);
        prog[3] = mk(3, 8, 1, 9, 1, 0, 0);
        prog[4] = mk(4, 10, 1, 11, 1, 0, 0);
        run_prog("prog R7");
        chk("R7 stalls", n_stall, 0);
        chk("R7 reader1 mem", fwd_seen[1], 2);
        chk("R7 reader2 wb", fwd_seen[2], 1);
        chk("R7 reader3 file", fwd_seen[3], 0);

        // R9: load then immediate user.
        plen = 2;
        prog[0] = mk(0, 1, 2, 0, 1, 1, 0);
        prog[1] = mk(1, 4, 1, 3, 1, 0, 0);
        run_prog("prog R9");
        chk("R9 stalls", n_stall, 1);
        chk("R9 user via wb", fwd_seen[1], 1);

        // R8: taken branch kills one fetch.
        plen = 3;
        prog[0] = mk(0, 0, 1, 2, 0, 0, 1);
        prog[1] = mk(1, 5, 0, 0, 1, 0, 0);
        prog[2] = mk(2, 6, 0, 0, 1, 0, 0);
        run_prog("prog R8");
        chk("R8 kills", n_kill, 1);
        chk("R8 killed never executes", fwd_seen[1], -1);

        // Mixed patterns over a small register range (all requirements).
        for (int i = 0; i < 400; i++) begin
            id_rs1 = 5'($urandom_range(0, 3)); id_rs2 = 5'($urandom_range(0, 3));
            ex_rs1 = 5'($urandom_range(0, 3)); ex_rs2 = 5'($urandom_range(0, 3));
            ex_rd  = 5'($urandom_range(0, 3)); mem_rd = 5'($urandom_range(0, 3));
            wb_rd  = 5'($urandom_range(0, 3));
            ex_wr = 1'($urandom); ex_ld = 1'($urandom); mem_wr = 1'($urandom);
            mem_ld = 1'($urandom); wb_wr = 1'($urandom); br = 1'($urandom);
            step("mixed");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule